// File: doc/BRIEF.md
# Hiccup-Mode Overload Restart Controller

This block sits beside the digital PWM generator of a switching power stage and decides how the stage reacts to overload. A comparator outside the block raises a current-limit flag whenever the sensed switch current passes its limit. The block ends the running switching cycle at once whenever that happens. Over many periods it also keeps an up/down persistence count: the count rises for each switching period that held a limit event and falls for each period that held none. A short load transient therefore drains away. An overload that lasts pushes the count up to a programmable trip level.

When the trip level is reached, the controller stops switching, holds the external soft-start ramp in reset and sleeps. The sleep ends only when two conditions hold: a programmable tick timer has run out, and the persistence count has drained, one step per switching period, down to a programmable wake level. The controller then releases soft-start, spends a programmable number of periods in a soft-start phase and returns to normal running. If the fault is still present, it counts up again and the loop repeats. A bypass input turns the block into a plain cycle-by-cycle limiter that never sleeps.

A typical setting is a trip level of 100 periods at a 250 kHz switching rate with 500 µs of sleep. At a 100 MHz clock that sleep is 50 000 ticks, which fits the default 16-bit timer.

Top module: `hiccup_ctrl`

## Requirements
- R1: `cyc_term` is high in the same cycle as `ilim_flag` whenever `pwm_en` is high, and low whenever `pwm_en` is low.
- R2: Outside sleep, at each `cyc_strobe` the persistence count rises by one if a limit event was seen since the previous strobe, and otherwise falls by one. The strobe cycle itself counts as part of the period that it ends. The count saturates at zero and at its all-ones maximum. A burst of fewer than `trip_level` faulty periods that starts from a zero count never causes sleep, however long the clean stretch before it.
- R3: When the count is nonzero, is at least `trip_level`, and bypass is low, the phase becomes SLEEP on the next clock. While in SLEEP, `pwm_en` is 0 and `ss_reset` is 1. A burst of exactly `trip_level` faulty periods from a zero count causes sleep.
- R4: When the count has already drained to `wake_level`, SLEEP lasts exactly `sleep_ticks`+1 clock cycles.
- R5: In SLEEP the count falls by one at each strobe. SLEEP does not end while the count is above `wake_level`.
- R6: `ilim_flag` is ignored in SLEEP: it neither raises the count nor drives `cyc_term`.
- R7: On leaving SLEEP the phase becomes SOFTSTART and the count is cleared. `ss_release` is high for exactly that first SOFTSTART cycle, and `ss_reset` returns low.
- R8: SOFTSTART lasts `ss_cycles` strobes (at least one), then the phase becomes RUN.
- R9: Under a fault that never clears, the sleep, soft-start and count sequence repeats, and every sleep has the programmed length.
- R10: While `hiccup_bypass` is high the phase never enters SLEEP, the count is held at zero, and `cyc_term` still follows `ilim_flag`.
- R11: The phase encoding is SOFTSTART=0, RUN=1, SLEEP=2. During reset the phase is SOFTSTART, the count is zero, `pwm_en`=1, `ss_reset`=0 and `ss_release`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-cycle pulse that ends each switching period |
| ilim_flag | input | 1 | Cycle-by-cycle current-limit comparator flag |
| hiccup_bypass | input | 1 | 1 = limit each cycle only, never sleep |
| trip_level | input | CNT_W | Count at which sleep starts |
| wake_level | input | CNT_W | Count at or below which sleep may end |
| sleep_ticks | input | TMR_W | Minimum sleep length in clock ticks, minus one |
| ss_cycles | input | SS_W | Length of the soft-start phase in switching periods |
| cyc_term | output | 1 | Terminate the present switching cycle |
| pwm_en | output | 1 | Switching allowed |
| ss_reset | output | 1 | Hold the soft-start ramp discharged |
| ss_release | output | 1 | One-cycle pulse when soft-start is released |
| phase | output | 2 | Current phase (SOFTSTART=0, RUN=1, SLEEP=2) |

## Verification
The properties take for granted that `cyc_strobe` is a single-cycle pulse with at least two clocks between pulses, and that the levels and tick counts stay constant while the block runs. The trip level is assumed to be below the count maximum, and the wake level below the trip level. The stimulus uses a free-running strobe every eight clocks. Thresholds change only inside a reset, and every fault burst starts and ends on the clock just after a strobe, so each burst covers a known whole number of periods.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
    typedef enum logic [1:0] {
        PH_SOFT  = 2'd0,
        PH_RUN   = 2'd1,
        PH_SLEEP = 2'd2
    } phase_e;
endpackage

// File: rtl/hiccup_persist.sv
// Up/down persistence counter of faulty switching periods.
module hiccup_persist #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             ilim,
    input  logic             count_en,
    input  logic             drain_en,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] cnt;
    } pers_t;

    pers_t st_d, st_q;
    logic  event_w;

    always_comb begin
        st_d    = st_q;
        event_w = st_q.seen | ilim;
        if (count_en) begin
            st_d.seen = strobe ? 1'b0 : event_w;
        end else begin
            st_d.seen = 1'b0;
        end
        if (strobe) begin
            if (count_en) begin
                if (event_w) begin
                    if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + ONE;
                end else if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end else if (drain_en) begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - ONE;
            end
        end
        if (clear) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/hiccup_timer.sv
// Sleep down-counter of clock ticks, loaded on sleep entry.
module hiccup_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    typedef struct packed {
        logic [TMR_W-1:0] ticks;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ticks = load_val;
        end else if (st_q.ticks != '0) begin
            st_d.ticks = st_q.ticks - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero = (st_q.ticks == '0);
endmodule

// File: rtl/hiccup_seq.sv
// Phase sequencer: RUN -> SLEEP -> SOFTSTART -> RUN.
module hiccup_seq #(
    parameter int CNT_W = 8,
    parameter int SS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic               bypass,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]   trip_level,
    input  logic [CNT_W-1:0]   wake_level,
    input  logic [SS_W-1:0]    ss_cycles,
    input  logic               tmr_zero,
    output hiccup_pkg::phase_e phase,
    output logic               enter_sleep,
    output logic               enter_soft,
    output logic               ss_release
);
    import hiccup_pkg::*;

    typedef struct packed {
        phase_e          ph;
        logic [SS_W-1:0] ss;
        logic            rel;
    } seq_t;

    seq_t          st_d, st_q;
    logic [SS_W:0] ss_next;

    always_comb begin
        st_d        = st_q;
        st_d.rel    = 1'b0;
        ss_next     = {1'b0, st_q.ss} + {{SS_W{1'b0}}, 1'b1};
        enter_sleep = !bypass && (st_q.ph != PH_SLEEP)
                      && (cnt != '0) && (cnt >= trip_level);
        enter_soft  = (st_q.ph == PH_SLEEP) && tmr_zero && (cnt <= wake_level);

        if (enter_sleep) begin
            st_d.ph = PH_SLEEP;
            st_d.ss = '0;
        end else begin
            unique case (st_q.ph)
                PH_SLEEP: begin
                    if (enter_soft) begin
                        st_d.ph  = PH_SOFT;
                        st_d.ss  = '0;
                        st_d.rel = 1'b1;
                    end
                end
                PH_SOFT: begin
                    if (strobe) begin
                        if (ss_next >= {1'b0, ss_cycles}) begin
                            st_d.ph = PH_RUN;
                            st_d.ss = '0;
                        end else begin
                            st_d.ss = ss_next[SS_W-1:0];
                        end
                    end
                end
                default: st_d.ph = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_SOFT;
            st_q.ss  <= '0;
            st_q.rel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.ph;
    assign ss_release = st_q.rel;
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl #(
    parameter int CNT_W = 8,
    parameter int TMR_W = 16,
    parameter int SS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_strobe,
    input  logic             ilim_flag,
    input  logic             hiccup_bypass,
    input  logic [CNT_W-1:0] trip_level,
    input  logic [CNT_W-1:0] wake_level,
    input  logic [TMR_W-1:0] sleep_ticks,
    input  logic [SS_W-1:0]  ss_cycles,
    output logic             cyc_term,
    output logic             pwm_en,
    output logic             ss_reset,
    output logic             ss_release,
    output logic [1:0]       phase
);
    import hiccup_pkg::*;

    phase_e           ph_w;
    logic             enter_sleep;
    logic             enter_soft;
    logic             tmr_zero;
    logic             sleeping;
    logic [CNT_W-1:0] persist_cnt;

    assign sleeping = (ph_w == PH_SLEEP);

    hiccup_persist #(.CNT_W(CNT_W)) u_persist (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (cyc_strobe),
        .ilim     (ilim_flag),
        .count_en (!sleeping && !hiccup_bypass),
        .drain_en (sleeping),
        .clear    (enter_soft || hiccup_bypass),
        .cnt      (persist_cnt)
    );

    hiccup_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter_sleep),
        .load_val (sleep_ticks),
        .zero     (tmr_zero)
    );

    hiccup_seq #(.CNT_W(CNT_W), .SS_W(SS_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (cyc_strobe),
        .bypass      (hiccup_bypass),
        .cnt         (persist_cnt),
        .trip_level  (trip_level),
        .wake_level  (wake_level),
        .ss_cycles   (ss_cycles),
        .tmr_zero    (tmr_zero),
        .phase       (ph_w),
        .enter_sleep (enter_sleep),
        .enter_soft  (enter_soft),
        .ss_release  (ss_release)
    );

    assign pwm_en   = !sleeping;
    assign ss_reset = sleeping;
    assign cyc_term = ilim_flag && !sleeping;
    assign phase    = ph_w;
endmodule

// File: rtl/hiccup_ctrl_chk.sv
module hiccup_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ilim_flag,
    input logic             hiccup_bypass,
    input logic             cyc_term,
    input logic             pwm_en,
    input logic             ss_reset,
    input logic             ss_release,
    input logic [1:0]       phase,
    input logic [CNT_W-1:0] trip_level,
    input logic [CNT_W-1:0] wake_level,
    input logic [CNT_W-1:0] cnt,
    input logic             tmr_zero
);
    import hiccup_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_term_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en && ilim_flag |-> cyc_term);

    p_no_wrap_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (cnt != CNT_MAX));

    p_no_wrap_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) && !hiccup_bypass && (phase != PH_SLEEP) |=> (cnt != '0));

    p_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hiccup_bypass && (phase != PH_SLEEP) && (cnt != '0) && (cnt >= trip_level)
        |=> (phase == PH_SLEEP));

    p_sleep_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP) |-> !pwm_en && ss_reset);

    p_timer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP) && !tmr_zero |=> (phase == PH_SLEEP));

    p_drain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP) && (cnt > wake_level) |=> (phase == PH_SLEEP));

    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP) |=> (cnt <= $past(cnt)));

    p_term_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |-> !cyc_term);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_release |-> (phase == PH_SOFT) && (cnt == '0) && !ss_reset
                       && ($past(phase) == PH_SLEEP));

    p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup_bypass && (phase != PH_SLEEP) |=> (phase != PH_SLEEP));
endmodule

bind hiccup_ctrl hiccup_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ilim_flag     (ilim_flag),
    .hiccup_bypass (hiccup_bypass),
    .cyc_term      (cyc_term),
    .pwm_en        (pwm_en),
    .ss_reset      (ss_reset),
    .ss_release    (ss_release),
    .phase         (phase),
    .trip_level    (trip_level),
    .wake_level    (wake_level),
    .cnt           (persist_cnt),
    .tmr_zero      (tmr_zero)
);

// File: tb/hiccup_ctrl_test.sv
`timescale 1ns/10ps
module hiccup_ctrl_test;
    localparam int CNT_W = 8;
    localparam int TMR_W = 16;
    localparam int SS_W  = 8;
    localparam int PER   = 8;
    localparam logic [1:0] P_SOFT = 2'd0, P_RUN = 2'd1, P_SLEEP = 2'd2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_strobe = 1'b0;
    logic             ilim_flag = 1'b0;
    logic             hiccup_bypass = 1'b0;
    logic [CNT_W-1:0] trip_level = 8'd10;
    logic [CNT_W-1:0] wake_level = 8'd2;
    logic [TMR_W-1:0] sleep_ticks = 16'd200;
    logic [SS_W-1:0]  ss_cycles = 8'd4;
    logic             cyc_term, pwm_en, ss_reset, ss_release;
    logic [1:0]       phase;

    hiccup_ctrl #(.CNT_W(CNT_W), .TMR_W(TMR_W), .SS_W(SS_W)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ilim_flag(ilim_flag),
        .hiccup_bypass(hiccup_bypass), .trip_level(trip_level), .wake_level(wake_level),
        .sleep_ticks(sleep_ticks), .ss_cycles(ss_cycles), .cyc_term(cyc_term),
        .pwm_en(pwm_en), .ss_reset(ss_reset), .ss_release(ss_release), .phase(phase)
    );

    always #2.5 clk = ~clk;

    int errs = 0;
    int checks = 0;
    int ph = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // free-running period strobe, one pulse every PER clocks
    always @(negedge clk) begin
        ph = (ph == PER-1) ? 0 : ph + 1;
        cyc_strobe = (ph == PER-1);
    end

    // scoreboard: expected sleep lengths pushed by the driver, popped by the monitor
    int exp_q[$];
    int slp_len = 0;
    int slp_cnt = 0;
    int last_len = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            slp_len = 0;
        end else if (phase == P_SLEEP) begin
            slp_len++;
        end else if (slp_len > 0) begin
            slp_cnt++;
            last_len = slp_len;
            chk(ss_release == 1'b1 && phase == P_SOFT, "R7 release pulse on sleep exit",
                int'(ss_release), 1);
            if (exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                chk(slp_len == e, "R4/R9 sleep length", slp_len, e);
            end
            slp_len = 0;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic sync_period;
        do begin
            @(negedge clk);
            #1;
        end while (ph != 0);
    endtask

    task automatic periods(input int n);
        wait_clks(n * PER);
    endtask

    task automatic burst(input int n);
        sync_period();
        ilim_flag = 1'b1;
        periods(n);
        ilim_flag = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        ilim_flag = 1'b0;
        wait_clks(3);
        sync_period();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int base;
        int guard;

        // R11: reset state
        wait_clks(3);
        chk(phase == P_SOFT, "R11 reset phase", phase, P_SOFT);
        chk(pwm_en == 1'b1 && ss_reset == 1'b0 && ss_release == 1'b0,
            "R11 reset outputs", {pwm_en, ss_reset, ss_release}, 3'b100);
        sync_period();
        rst_n = 1'b1;

        // R8: soft-start length of ss_cycles=4 strobes
        wait_clks(3 * PER);
        chk(phase == P_SOFT, "R8 still soft-start after 3 strobes", phase, P_SOFT);
        wait_clks(2 * PER);
        chk(phase == P_RUN, "R8 run after 4 strobes", phase, P_RUN);

        // R1: immediate cycle termination
        sync_period();
        wait_clks(3);
        ilim_flag = 1'b1;
        #0.5;
        chk(cyc_term == 1'b1, "R1 cyc_term follows ilim", cyc_term, 1);
        ilim_flag = 1'b0;
        #0.5;
        chk(cyc_term == 1'b0, "R1 cyc_term drops", cyc_term, 0);
        periods(20);

        // R2: transients below the trip level never sleep
        base = slp_cnt;
        burst(9);
        periods(20);
        chk(slp_cnt == base, "R2 burst of trip-1 periods", slp_cnt - base, 0);
        for (int i = 0; i < 15; i++) begin
            burst(1);
            periods(1);
        end
        chk(slp_cnt == base && phase == P_RUN, "R2 alternating pattern", slp_cnt - base, 0);
        periods(40);
        burst(9);
        periods(5);
        chk(slp_cnt == base, "R2 zero saturation after idle", slp_cnt - base, 0);
        periods(15);

        // R3/R4/R6: exact trip burst, timer-bounded sleep
        exp_q.push_back(int'(sleep_ticks) + 1);
        burst(10);
        wait_clks(2);
        chk(phase == P_SLEEP, "R3 sleep after trip burst", phase, P_SLEEP);
        chk(pwm_en == 1'b0 && ss_reset == 1'b1, "R3 sleep outputs",
            {pwm_en, ss_reset}, 2'b01);
        ilim_flag = 1'b1;
        #0.5;
        chk(cyc_term == 1'b0, "R6 no termination in sleep", cyc_term, 0);
        ilim_flag = 1'b0;
        wait_clks(300);
        chk(slp_cnt == base + 1, "R3 one sleep", slp_cnt - base, 1);
        chk(phase == P_RUN, "R8 back to run after sleep", phase, P_RUN);

        // R9: continuous fault repeats with exact sleeps
        base = slp_cnt;
        repeat (3) exp_q.push_back(int'(sleep_ticks) + 1);
        sync_period();
        ilim_flag = 1'b1;
        guard = 0;
        while (slp_cnt < base + 3 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        #1;
        ilim_flag = 1'b0;
        chk(slp_cnt == base + 3, "R9 three repeated sleeps", slp_cnt - base, 3);
        chk(exp_q.size() == 0, "R9 all expected sleeps seen", exp_q.size(), 0);
        periods(50);
        chk(slp_cnt == base + 3, "R9 no sleep after fault clears", slp_cnt - base, 3);

        // R5/R6: drain-bounded sleep with fault held through it
        sleep_ticks = 16'd5;
        wake_level = 8'd0;
        do_reset();
        periods(6);
        base = slp_cnt;
        sync_period();
        ilim_flag = 1'b1;
        guard = 0;
        while (slp_cnt < base + 1 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        #1;
        ilim_flag = 1'b0;
        chk(slp_cnt == base + 1, "R6 sleep ends despite held fault", slp_cnt - base, 1);
        chk(last_len >= 70 && last_len <= 82, "R5 sleep set by drain", last_len, 80);

        // R10: bypass never sleeps
        sleep_ticks = 16'd200;
        wake_level = 8'd2;
        do_reset();
        periods(6);
        base = slp_cnt;
        hiccup_bypass = 1'b1;
        sync_period();
        ilim_flag = 1'b1;
        periods(60);
        #0.5;
        chk(cyc_term == 1'b1, "R10 bypass still terminates", cyc_term, 1);
        chk(pwm_en == 1'b1 && phase == P_RUN, "R10 bypass stays running", phase, P_RUN);
        chk(slp_cnt == base, "R10 no sleep in bypass", slp_cnt - base, 0);
        ilim_flag = 1'b0;
        periods(2);
        hiccup_bypass = 1'b0;
        periods(20);
        chk(slp_cnt == base, "R10 count held at zero in bypass", slp_cnt - base, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule